// File: doc/BRIEF.md
# Accumulator ALU With Flags

This block is the byte-wide arithmetic and logic unit of an accumulator machine. Each cycle in which `op_valid` is high, it combines the accumulator (`acc_in`) with a second operand (`opnd_in`) according to a four-bit operation code. The second operand can come from an immediate byte, a register or a memory byte; the surrounding datapath chooses which. The block presents the outcome on `result` and raises exactly one write strobe. `acc_we` asks for the result to go to the accumulator. `opnd_we` asks for it to go back to wherever the operand came from. Only increment and decrement use `opnd_we`.

Five status flags are held in a register inside the block and are exposed as `flags`. The layout is: bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry. The stored carry feeds add-with-carry and subtract-with-borrow, so that wider arithmetic can be chained as a sequence of byte steps. The auxiliary carry is taken at the boundary of the low half of the word, which is bit 3 at the default width of 8.

Top module: `acc_alu`

## Requirements
- R1: Op codes 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 XOR and 6 OR each put their outcome on `result` with `acc_we`=1 and `opnd_we`=0. The outcomes are acc+opnd, acc+opnd+CY, acc-opnd, acc-opnd-CY, acc&opnd, acc^opnd and acc|opnd, each taken modulo 2^DATA_W.
- R2: After ADD or ADC, carry (flags bit 0) equals the carry out of the top bit of the full sum. ADC adds the carry that was stored before the operation.
- R3: After SUB, SBB or code 7 CMP, carry is 1 exactly when a borrow occurred. SBB also subtracts the stored carry. CMP updates the flags as SUB would, but both write strobes stay 0.
- R4: Auxiliary carry (flags bit 2) follows the low DATA_W/2 bits. For ADD and ADC it is the carry out of those bits. For SUB, SBB and CMP it is the borrow from them, including any carry-in.
- R5: After any operation with code 0 to 9, sign (bit 4) equals the top bit of `result`, zero (bit 3) is 1 when `result` is 0, and parity (bit 1) is 1 when `result` has an even number of ones.
- R6: Code 8 INC puts opnd+1 and code 9 DEC puts opnd-1 on `result`, both modulo 2^DATA_W, with `opnd_we`=1 and `acc_we`=0. Carry keeps its previous value. Auxiliary carry is 1 for INC when the low half of opnd is all ones, and for DEC when the low half of opnd is zero.
- R7: AND sets auxiliary carry to 1 and carry to 0. XOR and OR set both to 0.
- R8: Code 10 CMA puts ~acc on `result` with `acc_we`=1 and leaves all five flags unchanged.
- R9: Code 11 STC sets carry to 1 and code 12 CMC inverts it. Both leave the other flags unchanged and both write strobes at 0.
- R10: While `op_valid` is 0, or for codes 13 to 15, both strobes are 0 and the flags hold.
- R11: Reset clears all five flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 4 | Operation code |
| acc_in | input | DATA_W | Accumulator value |
| opnd_in | input | DATA_W | Second operand, or the target of INC/DEC |
| result | output | DATA_W | Operation outcome |
| acc_we | output | 1 | Write `result` to the accumulator |
| opnd_we | output | 1 | Write `result` back to the operand's location |
| flags | output | 5 | {sign, zero, aux carry, parity, carry} |

## Verification
The bench builds the block with DATA_W=4, so the auxiliary carry sits at bit 1. At that width every operation code can be applied to every pair of operands and to both values of the incoming carry, a little over six thousand cases. The sweep therefore reaches every carry and borrow boundary, both auxiliary boundaries, and every wrap of INC and DEC, with the expected flags worked out in integer arithmetic.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] result,
  output logic              acc_we,
  output logic              opnd_we,
  output logic [4:0]        flags
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
                         OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CMP = 4'd7,
                         OP_INC = 4'd8, OP_DEC = 4'd9, OP_CMA = 4'd10, OP_STC = 4'd11,
                         OP_CMC = 4'd12;

  logic [4:0] flags_q, flags_d;
  logic cin;
  logic [DATA_W:0] add_full, sub_full;
  logic [HALF_W:0] add_low, sub_low;
  logic [DATA_W-1:0] res;
  logic cy_n, ac_n, szp_upd, w_acc, w_opnd;

  assign cin = (op_sel == OP_ADC || op_sel == OP_SBB) & flags_q[0];
  assign add_full = {1'b0, acc_in} + {1'b0, opnd_in} + {{DATA_W{1'b0}}, cin};
  assign sub_full = {1'b0, acc_in} - {1'b0, opnd_in} - {{DATA_W{1'b0}}, cin};
  assign add_low  = {1'b0, acc_in[HALF_W-1:0]} + {1'b0, opnd_in[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
  assign sub_low  = {1'b0, acc_in[HALF_W-1:0]} - {1'b0, opnd_in[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin};

  always_comb begin
    res     = acc_in;
    cy_n    = flags_q[0];
    ac_n    = flags_q[2];
    szp_upd = 1'b0;
    w_acc   = 1'b0;
    w_opnd  = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        res = add_full[DATA_W-1:0]; cy_n = add_full[DATA_W]; ac_n = add_low[HALF_W];
        szp_upd = 1'b1; w_acc = 1'b1;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        res = sub_full[DATA_W-1:0]; cy_n = sub_full[DATA_W]; ac_n = sub_low[HALF_W];
        szp_upd = 1'b1; w_acc = (op_sel != OP_CMP);
      end
      OP_AND: begin
        res = acc_in & opnd_in; cy_n = 1'b0; ac_n = 1'b1; szp_upd = 1'b1; w_acc = 1'b1;
      end
      OP_XOR: begin
        res = acc_in ^ opnd_in; cy_n = 1'b0; ac_n = 1'b0; szp_upd = 1'b1; w_acc = 1'b1;
      end
      OP_OR: begin
        res = acc_in | opnd_in; cy_n = 1'b0; ac_n = 1'b0; szp_upd = 1'b1; w_acc = 1'b1;
      end
      OP_INC: begin
        res = opnd_in + {{(DATA_W-1){1'b0}}, 1'b1}; ac_n = &opnd_in[HALF_W-1:0];
        szp_upd = 1'b1; w_opnd = 1'b1;
      end
      OP_DEC: begin
        res = opnd_in - {{(DATA_W-1){1'b0}}, 1'b1}; ac_n = ~|opnd_in[HALF_W-1:0];
        szp_upd = 1'b1; w_opnd = 1'b1;
      end
      OP_CMA: begin
        res = ~acc_in; w_acc = 1'b1;
      end
      OP_STC: cy_n = 1'b1;
      OP_CMC: cy_n = ~flags_q[0];
      default: ;
    endcase
  end

  always_comb begin
    flags_d = {flags_q[4:3], ac_n, flags_q[1], cy_n};
    if (szp_upd) flags_d = {res[DATA_W-1], ~|res, ac_n, ~^res, cy_n};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flags_q <= 5'b0;
    else if (op_valid) flags_q <= flags_d;

  assign result  = res;
  assign acc_we  = op_valid & w_acc;
  assign opnd_we = op_valid & w_opnd;
  assign flags   = flags_q;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] result,
  input logic              acc_we,
  input logic              opnd_we,
  input logic [4:0]        flags
);
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_we, opnd_we}));
  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd7) |-> (!acc_we && !opnd_we));
  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 4'd9) |=> flags[1] == ~^$past(result));
  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 4'd9) |=> flags[4] == $past(result[DATA_W-1]));
  assert_incdec_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 4'd8 || op_sel == 4'd9)) |=> flags[0] == $past(flags[0]));
  assert_and_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd4) |=> (flags[2] && !flags[0]));
  assert_cma_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd10) |=> $stable(flags));
  assert_stc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd11) |=> flags[0]);
  assert_cmc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd12) |=> flags[0] != $past(flags[0]));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags));
endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .result(result), .acc_we(acc_we), .opnd_we(opnd_we), .flags(flags));

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int W = 4;
  localparam int M = 1 << W;
  localparam int H = 1 << (W / 2);

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [W-1:0] acc_in = '0, opnd_in = '0, result;
  logic acc_we, opnd_we;
  logic [4:0] flags;
  int n_chk = 0, n_fail = 0;
  logic [W-1:0] s_res;
  logic s_aw, s_ow;

  always #2 clk = ~clk;

  acc_alu #(.DATA_W(W)) u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .result(result),
    .acc_we(acc_we), .opnd_we(opnd_we), .flags(flags));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input int a, input int b, input logic v);
    @(negedge clk);
    op_valid = v; op_sel = op; acc_in = W'(a); opnd_in = W'(b);
    #1;
    s_res = result; s_aw = acc_we; s_ow = opnd_we;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic int par_even(input int r);
    int c = 0;
    for (int i = 0; i < W; i++) c += (r >> i) & 1;
    return (c % 2 == 0) ? 1 : 0;
  endfunction

  initial begin
    #(150000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e_res, e_cy, e_ac, e_s, e_z, e_p, e_aw, e_ow, cin, d;
    logic [4:0] pre, e_fl;
    #9 rst_n = 1'b1;
    @(negedge clk);
    chk(flags == 5'b0, "R11 reset flags", flags, 0);
    chk(acc_we == 1'b0 && opnd_we == 1'b0, "R10 idle strobes", {acc_we, opnd_we}, 0);

    for (int op = 0; op <= 15; op++)
      for (int cy = 0; cy < 2; cy++)
        for (int a = 0; a < M; a++)
          for (int b = 0; b < M; b++) begin
            run(4'd11, 0, 0, 1'b1);
            if (cy == 0) run(4'd12, 0, 0, 1'b1);
            pre = flags;
            chk(pre[0] == cy[0], "R9 carry set up", pre[0], cy);
            if (op >= 13 && (a % 5 != 0 || b % 5 != 0)) continue;
            run(4'(op), a, b, 1'b1);
            e_cy = pre[0]; e_ac = pre[2]; e_res = a; e_aw = 0; e_ow = 0;
            cin = (op == 1 || op == 3) ? cy : 0;
            case (op)
              0, 1: begin
                e_res = (a + b + cin) % M; e_cy = (a + b + cin >= M);
                e_ac = ((a % H) + (b % H) + cin >= H); e_aw = 1;
              end
              2, 3, 7: begin
                d = a - b - cin; e_res = (d + 2 * M) % M; e_cy = (d < 0);
                e_ac = ((a % H) - (b % H) - cin < 0); e_aw = (op != 7);
              end
              4: begin e_res = a & b; e_cy = 0; e_ac = 1; e_aw = 1; end
              5: begin e_res = a ^ b; e_cy = 0; e_ac = 0; e_aw = 1; end
              6: begin e_res = a | b; e_cy = 0; e_ac = 0; e_aw = 1; end
              8: begin e_res = (b + 1) % M; e_ac = (b % H == H - 1); e_ow = 1; end
              9: begin e_res = (b + M - 1) % M; e_ac = (b % H == 0); e_ow = 1; end
              10: begin e_res = (~a) & (M - 1); e_aw = 1; end
              11: e_cy = 1;
              12: e_cy = 1 - pre[0];
              default: ;
            endcase
            e_s = (e_res >> (W - 1)) & 1; e_z = (e_res == 0); e_p = par_even(e_res);
            if (op <= 9) e_fl = {e_s[0], e_z[0], e_ac[0], e_p[0], e_cy[0]};
            else e_fl = {pre[4:3], e_ac[0], pre[1], e_cy[0]};
            if (op <= 10)
              chk(int'(s_res) == e_res, (op <= 7) ? "R1 result" : (op <= 9) ? "R6 result" : "R8 result", s_res, e_res);
            chk(s_aw == e_aw[0] && s_ow == e_ow[0],
                (op == 7) ? "R3 cmp strobes" : (op >= 13) ? "R10 unused code strobes" : "R1 strobes",
                {s_aw, s_ow}, {e_aw[0], e_ow[0]});
            chk(flags == e_fl,
                (op <= 1) ? "R2 R4 R5 add flags" : (op <= 3 || op == 7) ? "R3 R4 R5 sub flags" :
                (op <= 6) ? "R7 R5 logic flags" : (op <= 9) ? "R6 R5 incdec flags" :
                (op == 10) ? "R8 cma flags" : (op <= 12) ? "R9 carry ops" : "R10 unused code flags",
                flags, e_fl);
          end

    run(4'd11, 0, 0, 1'b1);
    pre = flags;
    run(4'd4, 5, 3, 1'b0);
    chk(s_aw == 1'b0 && s_ow == 1'b0, "R10 invalid strobes", {s_aw, s_ow}, 0);
    chk(flags == pre, "R10 invalid hold", flags, pre);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule